// File: doc/BRIEF.md
# Memory Region Decoder with Wait-State Control

This block sits between a segmented CPU bus and the memory system. Each access carries a 7-bit segment number and a 16-bit offset. The block joins them into one linear address and classifies that address. It can fall in local memory, in main memory, in the dead hole that appears when local memory is switched on, or in unmapped space. For each access it drives one region select, or an error flag when no memory answers. It then stretches the access by the right number of wait states.

On the data side, the block works out which byte lanes of the 16-bit memory path are enabled. On byte reads it places the selected byte onto the half of the CPU bus given by the low address bit. While the translation-enable bit is clear, main-memory addresses go straight to memory as the bypass address, and no translation request is raised. Programming cycles for the translation units pass through whatever that bit holds.

The request side uses a valid/ready handshake. An access is taken on a rising edge where `req_valid` and `req_ready` are both high. The request fields need to be stable only in that cycle. `req_ready` is low during every wait cycle of the access in progress. A requester that keeps `req_valid` high is therefore held off until the access completes. Its request is taken on the edge that ends the completion cycle, so accesses can run back to back.

Top module: `mem_region_decoder`

## Requirements
- R1: With `lm_en` high, a linear address {segment, offset} below 0x002800 raises `sel_local` and no other select.
- R2: With `lm_en` high, linear addresses 0x002800 to 0x003FFF raise `dec_err` and neither select.
- R3: Any linear address of 0x004000 or above raises `sel_main`. With `lm_en` low, every address below 0x004000 raises `dec_err` and neither select.
- R4: A local access has one wait state. `mem_wait` is high and `acc_done` is low in the first cycle after acceptance. `acc_done` is high and `mem_wait` is low in the second cycle.
- R5: A main access completes with `acc_done` in the first cycle after acceptance and no wait, unless `ecc_fix` was high at acceptance. In that case it has one wait state, as in R4.
- R6: A failed decode completes in the first cycle after acceptance with no wait, whatever the value of `ecc_fix`.
- R7: `lane_hi` is the even/upper byte lane (data bits 15:8) and `lane_lo` is the odd/lower lane (bits 7:0). Word accesses (`req_byte` = 0) and byte reads enable both lanes. A byte write enables only `lane_hi` when address bit 0 is 0, and only `lane_lo` when it is 1. Failed decodes enable no lane.
- R8: In the completion cycle of a read, `cpu_rdata` carries `mem_rdata` for a word. For a byte at an even address it carries {mem_rdata[15:8], 8'h00}; for an odd address, {8'h00, mem_rdata[7:0]}. Writes and failed decodes give zero.
- R9: While translation is disabled, `bypass_addr` = {1'b0, segment, offset} during a decoded access, and `xlat_req` stays low. It is zero when the decode failed or no access is active.
- R10: The translation-enable bit is cleared by reset and loaded from `ctl_mmu_on` on a clock where `ctl_load` is high. While it is set, a main access raises `xlat_req` and `bypass_addr` reads zero.
- R11: `mmu_prog` follows `mmu_io` in the same cycle, whatever the state of the translation-enable bit.
- R12: `req_ready` is low in every wait cycle. Selects, lanes and `bypass_addr` hold steady from the first cycle after acceptance through completion. A request held valid during a wait is taken only at the end of the completion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_load | input | 1 | Load strobe for the translation-enable bit |
| ctl_mmu_on | input | 1 | New value of the translation-enable bit |
| lm_en | input | 1 | Local memory enable, sampled at acceptance |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can take a request |
| req_seg | input | 7 | Segment number |
| req_off | input | 16 | Offset within segment |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_byte | input | 1 | 1 = byte access, 0 = word |
| ecc_fix | input | 1 | Error correction active on this access |
| mmu_io | input | 1 | Translation-unit programming cycle |
| mmu_prog | output | 1 | Programming strobe to translation units |
| sel_local | output | 1 | Local memory select |
| sel_main | output | 1 | Main memory select |
| dec_err | output | 1 | Dead or unmapped address |
| mem_wait | output | 1 | Wait state in progress |
| acc_done | output | 1 | Last cycle of the access |
| lane_hi | output | 1 | Upper (even) byte lane enable |
| lane_lo | output | 1 | Lower (odd) byte lane enable |
| bypass_addr | output | 24 | Untranslated physical address |
| xlat_req | output | 1 | Main access routed through translation |
| mem_rdata | input | 16 | Data from memory |
| cpu_rdata | output | 16 | Data steered to the CPU bus |

## Verification
The captured region and the wait counter reach the ports in the first cycle after acceptance. A wrong region code shows there at once as the wrong select, a missing error flag, or a lane pattern that does not fit the access. A counter loaded with the wrong count shows within one further cycle, as a `mem_wait` that never rises or never falls, an early or late `acc_done`, or `req_ready` going high during a wait. A wrong translation-enable bit shows on the very next main access, as a nonzero or zero `bypass_addr` and a wrong `xlat_req`.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  typedef enum logic [1:0] {
    RG_NONE  = 2'd0,
    RG_LOCAL = 2'd1,
    RG_MAIN  = 2'd2,
    RG_HOLE  = 2'd3
  } region_e;
endpackage

// File: rtl/mrd_region_decode.sv
module mrd_region_decode
  import mrd_pkg::*;
#(
  parameter int LIN_W     = 23,
  parameter int LOCAL_TOP = 'h2800,
  parameter int MAIN_BASE = 'h4000
) (
  input  logic [LIN_W-1:0] lin,
  input  logic             lm_en,
  output region_e          region
);
  localparam logic [LIN_W-1:0] LT = LIN_W'(LOCAL_TOP);
  localparam logic [LIN_W-1:0] MB = LIN_W'(MAIN_BASE);

  always_comb begin
    if (lin >= MB)                region = RG_MAIN;
    else if (!lm_en)              region = RG_NONE;
    else if (lin < LT)            region = RG_LOCAL;
    else                          region = RG_HOLE;
  end

  always_comb begin
    assert_hole_bounds_R2: assert (!(region == RG_HOLE) || (lm_en && lin >= LT && lin < MB));
  end
endmodule

// File: rtl/mrd_wait_ctl.sv
module mrd_wait_ctl
  import mrd_pkg::*;
#(
  parameter int WS_W     = 2,
  parameter int LOCAL_WS = 1,
  parameter int ECC_WS   = 1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  region_e region,
  input  logic    ecc,
  output logic    active,
  output logic    wait_o,
  output logic    done,
  output logic    ready
);
  logic [WS_W-1:0] cnt;
  logic [WS_W-1:0] need;

  always_comb begin
    unique case (region)
      RG_LOCAL: need = WS_W'(LOCAL_WS);
      RG_MAIN:  need = ecc ? WS_W'(ECC_WS) : '0;
      default:  need = '0;
    endcase
  end

  assign wait_o = active && (cnt != '0);
  assign done   = active && (cnt == '0);
  assign ready  = !active || done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= need;
    end else if (done) begin
      active <= 1'b0;
    end else if (wait_o) begin
      cnt <= cnt - 1'b1;
    end
  end

  assert_wait_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wait_o |-> !ready);
  assert_wait_keeps_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wait_o |=> active);
endmodule

// File: rtl/mrd_lane_steer.sv
module mrd_lane_steer #(
  parameter int DATA_W = 16
) (
  input  logic              hit,
  input  logic              is_byte,
  input  logic              is_rd,
  input  logic              a0,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              lane_hi,
  output logic              lane_lo,
  output logic [DATA_W-1:0] rdata
);
  localparam int HALF = DATA_W / 2;

  always_comb begin
    if (!hit) begin
      lane_hi = 1'b0;
      lane_lo = 1'b0;
    end else if (!is_byte || is_rd) begin
      lane_hi = 1'b1;
      lane_lo = 1'b1;
    end else begin
      lane_hi = !a0;
      lane_lo = a0;
    end
  end

  always_comb begin
    if (!is_byte)  rdata = mem_rdata;
    else if (a0)   rdata = {{HALF{1'b0}}, mem_rdata[HALF-1:0]};
    else           rdata = {mem_rdata[DATA_W-1:HALF], {HALF{1'b0}}};
  end
endmodule

// File: rtl/mem_region_decoder.sv
module mem_region_decoder
  import mrd_pkg::*;
#(
  parameter int SEG_W     = 7,
  parameter int OFF_W     = 16,
  parameter int DATA_W    = 16,
  parameter int LOCAL_TOP = 'h2800,
  parameter int MAIN_BASE = 'h4000,
  parameter int WS_W      = 2,
  parameter int LOCAL_WS  = 1,
  parameter int ECC_WS    = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ctl_load,
  input  logic                     ctl_mmu_on,
  input  logic                     lm_en,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [SEG_W-1:0]         req_seg,
  input  logic [OFF_W-1:0]         req_off,
  input  logic                     req_rd,
  input  logic                     req_byte,
  input  logic                     ecc_fix,
  input  logic                     mmu_io,
  output logic                     mmu_prog,
  output logic                     sel_local,
  output logic                     sel_main,
  output logic                     dec_err,
  output logic                     mem_wait,
  output logic                     acc_done,
  output logic                     lane_hi,
  output logic                     lane_lo,
  output logic [SEG_W+OFF_W:0]     bypass_addr,
  output logic                     xlat_req,
  input  logic [DATA_W-1:0]        mem_rdata,
  output logic [DATA_W-1:0]        cpu_rdata
);
  localparam int LIN_W  = SEG_W + OFF_W;
  localparam int PHYS_W = LIN_W + 1;

  logic [LIN_W-1:0] req_lin;
  region_e          req_region;
  logic             accept;
  logic             active;

  region_e          r_region;
  logic [LIN_W-1:0] r_lin;
  logic             r_rd;
  logic             r_byte;
  logic             mmu_on;

  logic             hit;
  logic [DATA_W-1:0] steer_data;

  assign req_lin = {req_seg, req_off};
  assign accept  = req_valid && req_ready;

  mrd_region_decode #(
    .LIN_W(LIN_W), .LOCAL_TOP(LOCAL_TOP), .MAIN_BASE(MAIN_BASE)
  ) u_dec (
    .lin(req_lin), .lm_en(lm_en), .region(req_region)
  );

  mrd_wait_ctl #(
    .WS_W(WS_W), .LOCAL_WS(LOCAL_WS), .ECC_WS(ECC_WS)
  ) u_wait (
    .clk(clk), .rst_n(rst_n), .start(accept), .region(req_region), .ecc(ecc_fix),
    .active(active), .wait_o(mem_wait), .done(acc_done), .ready(req_ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_region <= RG_NONE;
      r_lin    <= '0;
      r_rd     <= 1'b0;
      r_byte   <= 1'b0;
    end else if (accept) begin
      r_region <= req_region;
      r_lin    <= req_lin;
      r_rd     <= req_rd;
      r_byte   <= req_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        mmu_on <= 1'b0;
    else if (ctl_load) mmu_on <= ctl_mmu_on;
  end

  assign hit       = active && (r_region == RG_LOCAL || r_region == RG_MAIN);
  assign sel_local = active && (r_region == RG_LOCAL);
  assign sel_main  = active && (r_region == RG_MAIN);
  assign dec_err   = active && !hit;
  assign xlat_req  = sel_main && mmu_on;
  assign mmu_prog  = mmu_io;
  assign bypass_addr = (hit && !mmu_on) ? {1'b0, r_lin} : '0;

  mrd_lane_steer #(.DATA_W(DATA_W)) u_lane (
    .hit(hit), .is_byte(r_byte), .is_rd(r_rd), .a0(r_lin[0]),
    .mem_rdata(mem_rdata), .lane_hi(lane_hi), .lane_lo(lane_lo), .rdata(steer_data)
  );

  assign cpu_rdata = (acc_done && hit && r_rd) ? steer_data : '0;

  assert_one_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_local && sel_main));
  assert_err_no_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> !sel_local && !sel_main && !lane_hi && !lane_lo);
  assert_err_no_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> !mem_wait);
  assert_byte_write_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && r_byte && !r_rd) |-> $countones({lane_hi, lane_lo}) == 1);
  assert_bypass_inhibit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mmu_on |-> !xlat_req);
  assert_hold_in_wait_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wait && !ctl_load) |=> $stable(bypass_addr) && $stable(sel_local) && $stable(sel_main));
  assert_phys_top_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass_addr[PHYS_W-1]);
endmodule

// File: tb/mem_region_decoder_tb.sv
module mem_region_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_load = 1'b0, ctl_mmu_on = 1'b0, lm_en = 1'b0;
  logic req_valid = 1'b0, req_rd = 1'b0, req_byte = 1'b0, ecc_fix = 1'b0, mmu_io = 1'b0;
  logic [6:0]  req_seg = '0;
  logic [15:0] req_off = '0;
  logic [15:0] mem_rdata = 16'hC3A5;
  logic req_ready, mmu_prog, sel_local, sel_main, dec_err, mem_wait, acc_done;
  logic lane_hi, lane_lo, xlat_req;
  logic [23:0] bypass_addr;
  logic [15:0] cpu_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mem_region_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_load(ctl_load), .ctl_mmu_on(ctl_mmu_on), .lm_en(lm_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg), .req_off(req_off),
    .req_rd(req_rd), .req_byte(req_byte), .ecc_fix(ecc_fix), .mmu_io(mmu_io),
    .mmu_prog(mmu_prog), .sel_local(sel_local), .sel_main(sel_main), .dec_err(dec_err),
    .mem_wait(mem_wait), .acc_done(acc_done), .lane_hi(lane_hi), .lane_lo(lane_lo),
    .bypass_addr(bypass_addr), .xlat_req(xlat_req), .mem_rdata(mem_rdata), .cpu_rdata(cpu_rdata)
  );

  typedef struct packed {
    logic [6:0]  seg;
    logic [15:0] off;
    logic        rd;
    logic        byt;
    logic        lm;
    logic        ecc;
    logic [1:0]  sel;   // {local, main}
    logic        err;
    logic        ws;
    logic [1:0]  lanes; // {hi, lo}
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{7'h00, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 2'b10, 1'b0, 1'b1, 2'b11},
    '{7'h00, 16'h1000, 1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 1'b0, 1'b1, 2'b10},
    '{7'h00, 16'h27FF, 1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 1'b0, 1'b1, 2'b01},
    '{7'h00, 16'h2800, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 2'b00},
    '{7'h00, 16'h3FFF, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 2'b00},
    '{7'h00, 16'h4000, 1'b1, 1'b0, 1'b1, 1'b0, 2'b01, 1'b0, 1'b0, 2'b11},
    '{7'h00, 16'h4000, 1'b1, 1'b0, 1'b1, 1'b1, 2'b01, 1'b0, 1'b1, 2'b11},
    '{7'h00, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 2'b00},
    '{7'h00, 16'h3FFF, 1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 2'b00},
    '{7'h7F, 16'h0001, 1'b1, 1'b1, 1'b1, 1'b0, 2'b01, 1'b0, 1'b0, 2'b11},
    '{7'h01, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 1'b0, 1'b0, 2'b10},
    '{7'h00, 16'h0001, 1'b1, 1'b1, 1'b1, 1'b1, 2'b10, 1'b0, 1'b1, 2'b11},
    '{7'h00, 16'h4001, 1'b0, 1'b1, 1'b0, 1'b1, 2'b01, 1'b0, 1'b1, 2'b01}
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive a request at a falling edge, let it be accepted, return at the
  // falling edge of the first cycle after acceptance.
  task automatic issue(input logic [6:0] s, input logic [15:0] o, input logic rd,
                       input logic byt, input logic lm, input logic ecc);
    @(negedge clk);
    req_seg = s; req_off = o; req_rd = rd; req_byte = byt; lm_en = lm; ecc_fix = ecc;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [15:0] exp_rdata(input vec_t v);
    if (!v.rd || v.err) return 16'h0000;
    if (!v.byt)         return mem_rdata;
    return v.off[0] ? {8'h00, mem_rdata[7:0]} : {mem_rdata[15:8], 8'h00};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // Reset state (R10, R12)
    check("R12", "ready after reset", req_ready, 1);
    check("R4", "wait after reset", mem_wait, 0);
    check("R1", "selects after reset", {sel_local, sel_main, dec_err}, 0);
    check("R10", "xlat after reset", xlat_req, 0);

    // Vector table walk (R1..R9)
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      issue(v.seg, v.off, v.rd, v.byt, v.lm, v.ecc);
      check(v.err ? "R2" : "R1", "select", {sel_local, sel_main}, v.sel);
      check(v.lm ? "R3" : "R3", "error flag", dec_err, v.err);
      check("R7", "lanes", {lane_hi, lane_lo}, v.lanes);
      check("R9", "bypass", bypass_addr, v.err ? 24'h0 : {1'b0, v.seg, v.off});
      check("R9", "no xlat", xlat_req, 0);
      if (v.ws) begin
        check("R4", "wait first cycle", {mem_wait, acc_done}, 2'b10);
        check("R12", "ready in wait", req_ready, 0);
        @(negedge clk);
        check("R5", "done after wait", {mem_wait, acc_done}, 2'b01);
      end else begin
        check(v.err ? "R6" : "R5", "zero wait done", {mem_wait, acc_done}, 2'b01);
      end
      check("R8", "read data", cpu_rdata, exp_rdata(v));
    end

    // Programming strobe with translation off (R11)
    @(negedge clk) mmu_io = 1'b1;
    #1 check("R11", "prog with enable clear", mmu_prog, 1);
    @(negedge clk) mmu_io = 1'b0;
    #1 check("R11", "prog idle", mmu_prog, 0);

    // Enable translation (R10)
    @(negedge clk) begin ctl_load = 1'b1; ctl_mmu_on = 1'b1; end
    @(negedge clk) begin ctl_load = 1'b0; ctl_mmu_on = 1'b0; end
    issue(7'h00, 16'h4000, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R10", "xlat on main", xlat_req, 1);
    check("R10", "bypass zero", bypass_addr, 0);
    check("R10", "main select", sel_main, 1);
    issue(7'h00, 16'h0010, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R10", "no xlat on local", xlat_req, 0);
    @(negedge clk);
    mmu_io = 1'b1;
    #1 check("R11", "prog with enable set", mmu_prog, 1);
    mmu_io = 1'b0;

    // Reset clears the enable bit (R10)
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    issue(7'h02, 16'h1234, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R10", "xlat cleared by reset", xlat_req, 0);
    check("R9", "bypass after reset", bypass_addr, 24'h021234);

    // Back-pressure: second request held during wait (R12)
    @(negedge clk);
    req_seg = 7'h00; req_off = 16'h0100; req_rd = 1'b1; req_byte = 1'b0; lm_en = 1'b1; ecc_fix = 1'b0;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_off = 16'h5000; req_rd = 1'b0;
    check("R12", "ready low in wait", req_ready, 0);
    check("R4", "wait on local", mem_wait, 1);
    @(negedge clk);
    check("R12", "first held at done", bypass_addr, 24'h000100);
    check("R12", "done of first", {acc_done, sel_local}, 2'b11);
    @(negedge clk);
    req_valid = 1'b0;
    check("R12", "second accepted", {sel_main, acc_done}, 2'b11);
    check("R12", "second address", bypass_addr, 24'h005000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule